// File: doc/BRIEF.md
# Instruction Class Usage Profiler

The profiler watches the stream of instructions leaving the retirement stage of a core. Each retired instruction arrives as one accepted beat on a valid/ready input. The beat carries six class flags (vector/floating-point, predicated, branch, load-multiple or pop, store-multiple or push, DSP-like) and a small instruction-type identifier. The block keeps a saturating total for every class. It also keeps a sticky map of which instruction types have appeared at least once.

The stream is also cut into fixed windows of `INTERVAL_LEN` accepted instructions (1000 by default). For each window the block counts the vector instructions. When a window closes it records that count as the window's vector density, updates a peak density, and counts how many windows held at least one vector instruction. Software reads everything through a combinational register read port. A single clear strobe returns every statistic to zero.

The input never applies back-pressure. `in_ready` is held high, so a beat is taken on every cycle in which `in_valid` is high and `clr` is low. The upstream stage therefore never needs to stall or hold data for the profiler.

Top module: `instr_class_profiler`

## Requirements
- R1: `in_ready` is always 1. A beat is accepted in every cycle with `in_valid`=1 and `clr`=0, and each accepted beat adds one to the retired total (address 0).
- R2: Each accepted beat with `in_vec`=1 adds one to the vector total (address 1).
- R3: The predicated total (address 2) counts accepted beats with `in_pred`=1 and `in_branch`=0 only. The branch total (address 3) counts accepted beats with `in_branch`=1.
- R4: The load-multiple/pop total (address 4), store-multiple/push total (address 5) and DSP-like total (address 6) each count accepted beats carrying their own flag. The counts are independent of one another.
- R5: A window spans `INTERVAL_LEN` accepted beats (default 1000). It closes on the cycle its last beat is accepted, and that beat belongs to the closing window. The closed-window count is at address 7.
- R6: The covered-window count (address 8) rises by one when a closing window held at least one vector beat. It never exceeds the closed-window count.
- R7: Address 9 returns the vector count of the most recently closed window. Address 10 returns the largest such count since reset or clear.
- R8: Accepting a beat with `in_type`=k sets bit k of the used-type map (address 11). Address 12 holds the number of distinct types seen. Repeats of a type change neither value.
- R9: Cycles with `in_valid`=0 change no statistic, whatever the flags carry.
- R10: Every total saturates at all ones instead of wrapping.
- R11: `clr`=1 zeroes every statistic, the map and the window position on the next edge. When `clr` and `in_valid` are both high, the clear wins and the beat is dropped.
- R12: `rd_data` is combinational from `rd_addr`. Values are zero-extended, and unmapped addresses (13 to 15) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics |
| in_valid | input | 1 | Retired-instruction beat valid |
| in_ready | output | 1 | Always high; beat accepted when valid |
| in_vec | input | 1 | Vector/floating-point class flag |
| in_pred | input | 1 | Predicated (has condition) flag |
| in_branch | input | 1 | Branch flag |
| in_ldm | input | 1 | Load-multiple or pop flag |
| in_stm | input | 1 | Store-multiple or push flag |
| in_dsp | input | 1 | DSP-like flag |
| in_type | input | $clog2(NUM_TYPES) | Instruction-type identifier |
| rd_addr | input | 4 | Statistic select |
| rd_data | output | max(CNT_W, NUM_TYPES) | Selected statistic |

## Verification
The checker watches these properties on every cycle:
- `in_ready` stays high.
- An accepted beat moves the retired total by exactly one until it saturates, and a saturated total stays put.
- Idle cycles hold the totals and the window position still.
- A clear empties the state on the next edge.
- The window position stays in range, the covered count never passes the closed count, and the distinct-type count equals the population of the type map.

Other behaviours are shown only by the bench's scenarios:
- branches excluded from the predicated total;
- the exact cycle a window closes, and whether that beat is included in it;
- the density and peak values;
- the clear winning over a simultaneous beat.

// File: rtl/icp_pkg.sv
package icp_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_RETIRED   = 4'd0,
    RA_VECTOR    = 4'd1,
    RA_PRED      = 4'd2,
    RA_BRANCH    = 4'd3,
    RA_LDMPOP    = 4'd4,
    RA_STMPUSH   = 4'd5,
    RA_DSP       = 4'd6,
    RA_WINDOWS   = 4'd7,
    RA_COVERED   = 4'd8,
    RA_LAST_DENS = 4'd9,
    RA_PEAK_DENS = 4'd10,
    RA_USED_MAP  = 4'd11,
    RA_USED_CNT  = 4'd12
  } reg_addr_e;

  // Event counter slots, in the order the counter array is built.
  localparam int EV_RETIRED = 0;
  localparam int EV_VECTOR  = 1;
  localparam int EV_PRED    = 2;
  localparam int EV_BRANCH  = 3;
  localparam int EV_LDMPOP  = 4;
  localparam int EV_STMPUSH = 5;
  localparam int EV_DSP     = 6;
  localparam int NUM_EV     = 7;

endpackage

// File: rtl/icp_sat_counter.sv
module icp_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (clr)                   count <= '0;
    else if (inc && (count != TOP)) count <= count + 1'b1;
  end
endmodule

// File: rtl/icp_interval.sv
module icp_interval #(
  parameter int LEN = 1000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       acc,
  input  logic                       vec,
  output logic                       close_o,
  output logic                       hit_o,
  output logic [$clog2(LEN)-1:0]     pos_o,
  output logic [$clog2(LEN+1)-1:0]   last_o,
  output logic [$clog2(LEN+1)-1:0]   peak_o
);
  localparam int PW = $clog2(LEN);
  localparam int VW = $clog2(LEN+1);
  localparam logic [PW-1:0] LAST_POS = PW'(LEN - 1);

  logic [PW-1:0] pos;
  logic [VW-1:0] vcnt;
  logic [VW-1:0] vnext;
  logic          at_end;

  assign vnext  = vcnt + VW'(acc && vec);
  assign at_end = acc && (pos == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      vcnt   <= '0;
      last_o <= '0;
      peak_o <= '0;
    end else if (clr) begin
      pos    <= '0;
      vcnt   <= '0;
      last_o <= '0;
      peak_o <= '0;
    end else if (acc) begin
      if (at_end) begin
        pos    <= '0;
        vcnt   <= '0;
        last_o <= vnext;
        if (vnext > peak_o) peak_o <= vnext;
      end else begin
        pos  <= pos + 1'b1;
        vcnt <= vnext;
      end
    end
  end

  assign close_o = at_end;
  assign hit_o   = (vnext != '0);
  assign pos_o   = pos;
endmodule

// File: rtl/icp_usage_map.sv
module icp_usage_map #(
  parameter int NUM_TYPES = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           acc,
  input  logic [$clog2(NUM_TYPES)-1:0]   op,
  output logic [NUM_TYPES-1:0]           map_o,
  output logic [$clog2(NUM_TYPES+1)-1:0] cnt_o
);
  logic fresh;
  assign fresh = acc && !map_o[op];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_o <= '0;
      cnt_o <= '0;
    end else if (clr) begin
      map_o <= '0;
      cnt_o <= '0;
    end else if (fresh) begin
      map_o[op] <= 1'b1;
      cnt_o     <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/instr_class_profiler.sv
module instr_class_profiler
  import icp_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int INTERVAL_LEN = 1000,
  parameter int NUM_TYPES    = 32,
  localparam int OP_W = $clog2(NUM_TYPES),
  localparam int RD_W = (CNT_W > NUM_TYPES) ? CNT_W : NUM_TYPES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_vec,
  input  logic              in_pred,
  input  logic              in_branch,
  input  logic              in_ldm,
  input  logic              in_stm,
  input  logic              in_dsp,
  input  logic [OP_W-1:0]   in_type,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RD_W-1:0]   rd_data
);
  localparam int PW = $clog2(INTERVAL_LEN);
  localparam int VW = $clog2(INTERVAL_LEN + 1);
  localparam int UW = $clog2(NUM_TYPES + 1);

  logic              acc;
  logic [NUM_EV-1:0] ev_inc;
  logic [CNT_W-1:0]  ev_cnt [NUM_EV];
  logic              win_close, win_hit;
  logic [PW-1:0]     ival_pos;
  logic [VW-1:0]     last_dens, peak_dens;
  logic [CNT_W-1:0]  intv_cnt, cov_cnt;
  logic [NUM_TYPES-1:0] used_map;
  logic [UW-1:0]     used_cnt;

  assign in_ready = 1'b1;
  assign acc      = in_valid && !clr;

  always_comb begin
    ev_inc             = '0;
    ev_inc[EV_RETIRED] = acc;
    ev_inc[EV_VECTOR]  = acc && in_vec;
    ev_inc[EV_PRED]    = acc && in_pred && !in_branch;
    ev_inc[EV_BRANCH]  = acc && in_branch;
    ev_inc[EV_LDMPOP]  = acc && in_ldm;
    ev_inc[EV_STMPUSH] = acc && in_stm;
    ev_inc[EV_DSP]     = acc && in_dsp;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    icp_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(ev_inc[g]), .count(ev_cnt[g])
    );
  end

  icp_interval #(.LEN(INTERVAL_LEN)) u_ival (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc(acc), .vec(in_vec),
    .close_o(win_close), .hit_o(win_hit), .pos_o(ival_pos),
    .last_o(last_dens), .peak_o(peak_dens)
  );

  icp_sat_counter #(.W(CNT_W)) u_windows (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(win_close), .count(intv_cnt)
  );

  icp_sat_counter #(.W(CNT_W)) u_covered (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(win_close && win_hit), .count(cov_cnt)
  );

  icp_usage_map #(.NUM_TYPES(NUM_TYPES)) u_map (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc(acc), .op(in_type),
    .map_o(used_map), .cnt_o(used_cnt)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_RETIRED:   rd_data[CNT_W-1:0] = ev_cnt[EV_RETIRED];
      RA_VECTOR:    rd_data[CNT_W-1:0] = ev_cnt[EV_VECTOR];
      RA_PRED:      rd_data[CNT_W-1:0] = ev_cnt[EV_PRED];
      RA_BRANCH:    rd_data[CNT_W-1:0] = ev_cnt[EV_BRANCH];
      RA_LDMPOP:    rd_data[CNT_W-1:0] = ev_cnt[EV_LDMPOP];
      RA_STMPUSH:   rd_data[CNT_W-1:0] = ev_cnt[EV_STMPUSH];
      RA_DSP:       rd_data[CNT_W-1:0] = ev_cnt[EV_DSP];
      RA_WINDOWS:   rd_data[CNT_W-1:0] = intv_cnt;
      RA_COVERED:   rd_data[CNT_W-1:0] = cov_cnt;
      RA_LAST_DENS: rd_data[VW-1:0]    = last_dens;
      RA_PEAK_DENS: rd_data[VW-1:0]    = peak_dens;
      RA_USED_MAP:  rd_data[NUM_TYPES-1:0] = used_map;
      RA_USED_CNT:  rd_data[UW-1:0]    = used_cnt;
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/icp_checker.sv
module icp_checker #(
  parameter int CNT_W     = 32,
  parameter int LEN       = 1000,
  parameter int NUM_TYPES = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           clr,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic [CNT_W-1:0]               retired,
  input logic [CNT_W-1:0]               intervals,
  input logic [CNT_W-1:0]               covered,
  input logic [$clog2(LEN)-1:0]         pos,
  input logic [NUM_TYPES-1:0]           used_map,
  input logic [$clog2(NUM_TYPES+1)-1:0] used_cnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  a_r1_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  a_r1_accept_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr && retired != MAXV) |=> retired == $past(retired) + 1'b1);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> ($stable(retired) && $stable(pos)));

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (retired == MAXV && !clr) |=> retired == MAXV);

  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (retired == '0 && intervals == '0 && covered == '0 && pos == '0 && used_cnt == '0));

  a_r5_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pos) < LEN);

  a_r6_covered_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    covered <= intervals);

  a_r8_count_matches_map: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(used_map) == 32'(used_cnt));
endmodule

bind instr_class_profiler icp_checker #(
  .CNT_W(CNT_W), .LEN(INTERVAL_LEN), .NUM_TYPES(NUM_TYPES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
  .retired(ev_cnt[0]), .intervals(intv_cnt), .covered(cov_cnt), .pos(ival_pos),
  .used_map(used_map), .used_cnt(used_cnt)
);

// File: tb/instr_class_profiler_tb_top.sv
`timescale 1ns/1ps
module instr_class_profiler_tb_top;
  localparam int CNT_W = 12;
  localparam int LEN   = 1000;
  localparam int NT    = 16;
  localparam int OP_W  = 4;
  localparam int RD_W  = 16;

  logic clk = 0, rst_n = 0, clr = 0, in_valid = 0;
  logic in_ready;
  logic in_vec = 0, in_pred = 0, in_branch = 0, in_ldm = 0, in_stm = 0, in_dsp = 0;
  logic [OP_W-1:0] in_type = '0;
  logic [3:0]      rd_addr = '0;
  logic [RD_W-1:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  instr_class_profiler #(.CNT_W(CNT_W), .INTERVAL_LEN(LEN), .NUM_TYPES(NT)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_vec(in_vec), .in_pred(in_pred), .in_branch(in_branch), .in_ldm(in_ldm),
    .in_stm(in_stm), .in_dsp(in_dsp), .in_type(in_type),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Burst table: count, flags {vec,pred,br,ldm,stm,dsp}, type, expected
  // cumulative retired / vector / predicated totals after the burst.
  typedef struct packed {
    logic [7:0] n;
    logic [5:0] flags;
    logic [3:0] op;
    logic [7:0] e_ret;
    logic [7:0] e_vec;
    logic [7:0] e_pred;
  } burst_t;

  localparam burst_t TBL [6] = '{
    '{8'd3, 6'b010000, 4'd1, 8'd3,  8'd0, 8'd3},
    '{8'd2, 6'b011000, 4'd2, 8'd5,  8'd0, 8'd3},
    '{8'd4, 6'b100000, 4'd3, 8'd9,  8'd4, 8'd3},
    '{8'd1, 6'b110000, 4'd4, 8'd10, 8'd5, 8'd4},
    '{8'd5, 6'b000100, 4'd1, 8'd15, 8'd5, 8'd4},
    '{8'd2, 6'b000011, 4'd5, 8'd17, 8'd5, 8'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rdreg(input logic [3:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic send(input int n, input logic [5:0] f, input logic [3:0] op);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      {in_vec, in_pred, in_branch, in_ldm, in_stm, in_dsp} = f;
      in_type = op;
    end
    @(negedge clk);
    in_valid = 1'b0;
    {in_vec, in_pred, in_branch, in_ldm, in_stm, in_dsp} = '0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state of every mapped register (R12 map, all zero)
    for (int a = 0; a < 13; a++) begin
      rdreg(4'(a), v);
      check("R12 reset value", v, 0);
    end
    check("R1 ready high", int'(in_ready), 1);

    // Table walk: class totals (R1, R2, R3)
    foreach (TBL[i]) begin
      send(int'(TBL[i].n), TBL[i].flags, TBL[i].op);
      rdreg(4'd0, v); check("R1 retired total", v, int'(TBL[i].e_ret));
      rdreg(4'd1, v); check("R2 vector total", v, int'(TBL[i].e_vec));
      rdreg(4'd2, v); check("R3 predicated excl branch", v, int'(TBL[i].e_pred));
    end
    rdreg(4'd3, v); check("R3 branch total", v, 2);
    rdreg(4'd4, v); check("R4 ldm/pop total", v, 5);
    rdreg(4'd5, v); check("R4 stm/push total", v, 2);
    rdreg(4'd6, v); check("R4 dsp total", v, 2);
    rdreg(4'd11, v); check("R8 used map", v, 32'h3E);
    rdreg(4'd12, v); check("R8 distinct types", v, 5);
    rdreg(4'd13, v); check("R12 unmapped reads zero", v, 0);

    // R9: flags toggling with valid low have no effect
    @(negedge clk);
    {in_vec, in_pred, in_branch, in_ldm, in_stm, in_dsp} = 6'b111111;
    in_type = 4'd9;
    repeat (5) @(negedge clk);
    {in_vec, in_pred, in_branch, in_ldm, in_stm, in_dsp} = '0;
    rdreg(4'd0, v); check("R9 idle retired", v, 17);
    rdreg(4'd1, v); check("R9 idle vector", v, 5);
    rdreg(4'd11, v); check("R9 idle map", v, 32'h3E);

    // R11: clear zeroes everything
    do_clear();
    for (int a = 0; a < 13; a++) begin
      rdreg(4'(a), v);
      check("R11 cleared", v, 0);
    end

    // R5: window closes exactly on the 1000th beat, which is included
    send(999, 6'b000000, 4'd0);
    rdreg(4'd7, v); check("R5 no close at 999", v, 0);
    send(1, 6'b100000, 4'd0);
    rdreg(4'd7, v); check("R5 closed at 1000", v, 1);
    rdreg(4'd8, v); check("R6 covered after vec-last window", v, 1);
    rdreg(4'd9, v); check("R7 last density incl final beat", v, 1);
    rdreg(4'd10, v); check("R7 peak", v, 1);
    rdreg(4'd11, v); check("R8 type 0 bit", v, 1);

    send(500, 6'b000000, 4'd0);
    send(3, 6'b100000, 4'd0);
    send(497, 6'b000000, 4'd0);
    rdreg(4'd7, v); check("R5 windows", v, 2);
    rdreg(4'd8, v); check("R6 covered", v, 2);
    rdreg(4'd9, v); check("R7 last density", v, 3);
    rdreg(4'd10, v); check("R7 peak", v, 3);

    send(1000, 6'b000000, 4'd0);
    rdreg(4'd7, v); check("R5 windows", v, 3);
    rdreg(4'd8, v); check("R6 empty window not covered", v, 2);
    rdreg(4'd9, v); check("R7 last density zero", v, 0);
    rdreg(4'd10, v); check("R7 peak held", v, 3);
    rdreg(4'd0, v); check("R1 retired", v, 3000);

    // R10: saturation of the retired total (12-bit => 4095)
    send(1100, 6'b000000, 4'd0);
    rdreg(4'd0, v); check("R10 saturated retired", v, 4095);
    rdreg(4'd7, v); check("R5 windows after 4100", v, 4);

    // R11: clear and valid together, clear wins
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; in_vec = 1'b1; in_type = 4'd7;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0; in_vec = 1'b0;
    rdreg(4'd0, v); check("R11 clear beats valid retired", v, 0);
    rdreg(4'd1, v); check("R11 clear beats valid vector", v, 0);
    rdreg(4'd11, v); check("R11 clear beats valid map", v, 0);

    // R11: window count restarts from zero after clear
    send(999, 6'b000000, 4'd2);
    rdreg(4'd7, v); check("R11 window restart", v, 0);
    send(1, 6'b000000, 4'd2);
    rdreg(4'd7, v); check("R11 window restart close", v, 1);
    rdreg(4'd8, v); check("R6 no vector no cover", v, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule